// File: doc/BRIEF.md
# Banked Pin Function Selector with GPIO

This block owns a large set of chip pads, arranged as collections of eight pins. For every pin, a two-bit selector chooses who controls the pad. The pad can be driven as a plain general-purpose I/O, or it can be handed to one of three alternate peripheral clients. Each client supplies an output level and an output-enable for every pin.

In GPIO mode, software sets a per-pin drive-enable and a per-pin output level. Software reads the pad levels back through an input byte, which passes through a two-stage synchronizer. Software uses a byte-wide bus. A write lands on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`. Software updates one field by reading a byte, changing it and writing it back.

Every collection owns an eight-byte window. Collection c starts at byte address 0x20 + 8*c. Inside the window, the two selector bytes come first, followed by the drive byte and the output-level byte. The input byte sits at window offset 6.

Top module: `pinmux_gpio_bank`

## Requirements
- R1: After reset, every selector, drive and output-level register reads zero, every pin is a GPIO input, and `pad_oe` is all zero until the first register write.
- R2: Collection c decodes the byte addresses 0x20+8c to 0x20+8c+7. Pin j of that collection takes its selector from window byte 0 at bits [2j+1:2j] when j<4. When j>=4, the selector is in window byte 1 at bits [2(j-4)+1:2(j-4)]. Global pin number = 8c+j.
- R3: When a pin's selector is 0 (GPIO), `pad_oe` follows bit j of window byte 2 (drive, 1=output) and `pad_out` follows bit j of window byte 3. Both change on the clock edge that writes the byte.
- R4: Selector values 1, 2 and 3 route client A, B and C respectively (`cli_*_out`, `cli_*_oe`) to that pin's `pad_out` and `pad_oe`.
- R5: While a pin's selector is nonzero, its drive and output-level bits have no effect on the pad, and they take effect again once the selector returns to 0.
- R6: Window byte 6 reads the pad levels of the collection (bit j = pin j) through two flops. A change on `pad_in` that is set up before a clock edge shows up in the read data after the second edge and not after the first.
- R7: Window bytes 0 to 3 read back the last value written to them.
- R8: Reads of window bytes 4, 5 and 7, and of any address below 0x20 or at or above 0x20+8*NUM_COLL, return 0. Writes to those addresses and to window byte 6 change no register and no pad.
- R9: A write changes only the addressed byte of the addressed collection. All other bytes and collections keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pad_in | input | 144 | Pad input levels (asynchronous) |
| pad_out | output | 144 | Pad output levels |
| pad_oe | output | 144 | Pad output enables |
| cli_a_out | input | 144 | Client A output levels |
| cli_a_oe | input | 144 | Client A output enables |
| cli_b_out | input | 144 | Client B output levels |
| cli_b_oe | input | 144 | Client B output enables |
| cli_c_out | input | 144 | Client C output levels |
| cli_c_oe | input | 144 | Client C output enables |

## Verification
Every register drives the pads directly, so a corrupted selector, drive or level bit appears on `pad_out` or `pad_oe` in the cycle right after the faulty write. It also appears on `reg_rdata` as soon as that byte is addressed. A decode fault (wrong collection, wrong byte, or a selector field at the wrong bit pair) hands a pin to the wrong client. The bench catches this by giving each client a distinct per-pin pattern. A synchronizer that is one stage too short or too long is exposed by reading the input byte exactly one and two edges after a pad change.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  localparam int PINS_PER_COLL = 8;
  localparam int WIN_BYTES     = 8;

  typedef enum logic [1:0] {
    SEL_GPIO  = 2'd0,
    SEL_CLI_A = 2'd1,
    SEL_CLI_B = 2'd2,
    SEL_CLI_C = 2'd3
  } pin_sel_e;

  typedef enum logic [2:0] {
    WB_SEL_LO = 3'd0,
    WB_SEL_HI = 3'd1,
    WB_DRIVE  = 3'd2,
    WB_LEVEL  = 3'd3,
    WB_PADIN  = 3'd6
  } win_byte_e;

  // address lies inside one of the collection windows
  function automatic logic in_window(input int a, input int base, input int ncoll);
    return (a >= base) && (a < base + WIN_BYTES * ncoll);
  endfunction

  // collection number of an in-window address
  function automatic int coll_of(input int a, input int base);
    return (a - base) / WIN_BYTES;
  endfunction

  // byte position inside the window
  function automatic logic [2:0] byte_of(input int a, input int base);
    return 3'((a - base) % WIN_BYTES);
  endfunction

  // bytes that hold writable state
  function automatic logic byte_is_rw(input logic [2:0] b);
    return b <= 3'd3;
  endfunction

endpackage

// File: rtl/pmx_coll_regs.sv
module pmx_coll_regs
  import pmx_pkg::*;
#(
  parameter int NPIN = pmx_pkg::PINS_PER_COLL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_byte,
  input  logic [7:0]        wdata,
  output logic [2*NPIN-1:0] sel_q,
  output logic [NPIN-1:0]   drv_q,
  output logic [NPIN-1:0]   lvl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      drv_q <= '0;
      lvl_q <= '0;
    end else if (wr_en) begin
      case (wr_byte)
        WB_SEL_LO: sel_q[7:0]  <= wdata;
        WB_SEL_HI: sel_q[15:8] <= wdata;
        WB_DRIVE:  drv_q       <= wdata;
        WB_LEVEL:  lvl_q       <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pmx_pad_mux.sv
module pmx_pad_mux
  import pmx_pkg::*;
#(
  parameter int NUM_PINS = 144
) (
  input  logic [2*NUM_PINS-1:0] sel_vec,
  input  logic [NUM_PINS-1:0]   gpio_drv,
  input  logic [NUM_PINS-1:0]   gpio_lvl,
  input  logic [NUM_PINS-1:0]   a_out,
  input  logic [NUM_PINS-1:0]   a_oe,
  input  logic [NUM_PINS-1:0]   b_out,
  input  logic [NUM_PINS-1:0]   b_oe,
  input  logic [NUM_PINS-1:0]   c_out,
  input  logic [NUM_PINS-1:0]   c_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_sel_e sel;
    assign sel = pin_sel_e'(sel_vec[2*p +: 2]);
    always_comb begin
      case (sel)
        SEL_CLI_A: begin pad_out[p] = a_out[p]; pad_oe[p] = a_oe[p]; end
        SEL_CLI_B: begin pad_out[p] = b_out[p]; pad_oe[p] = b_oe[p]; end
        SEL_CLI_C: begin pad_out[p] = c_out[p]; pad_oe[p] = c_oe[p]; end
        default:   begin pad_out[p] = gpio_lvl[p]; pad_oe[p] = gpio_drv[p]; end
      endcase
    end
  end

endmodule

// File: rtl/pmx_in_sync.sv
module pmx_in_sync #(
  parameter int W = 144
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/pinmux_gpio_bank.sv
module pinmux_gpio_bank
  import pmx_pkg::*;
#(
  parameter int NUM_COLL  = 18,
  parameter int BASE_ADDR = 'h20,
  parameter int ADDR_W    = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    reg_addr,
  input  logic                                 reg_wr,
  input  logic [7:0]                           reg_wdata,
  output logic [7:0]                           reg_rdata,
  input  logic [NUM_COLL*PINS_PER_COLL-1:0]    pad_in,
  output logic [NUM_COLL*PINS_PER_COLL-1:0]    pad_out,
  output logic [NUM_COLL*PINS_PER_COLL-1:0]    pad_oe,
  input  logic [NUM_COLL*PINS_PER_COLL-1:0]    cli_a_out,
  input  logic [NUM_COLL*PINS_PER_COLL-1:0]    cli_a_oe,
  input  logic [NUM_COLL*PINS_PER_COLL-1:0]    cli_b_out,
  input  logic [NUM_COLL*PINS_PER_COLL-1:0]    cli_b_oe,
  input  logic [NUM_COLL*PINS_PER_COLL-1:0]    cli_c_out,
  input  logic [NUM_COLL*PINS_PER_COLL-1:0]    cli_c_oe
);

  localparam int NUM_PINS = NUM_COLL * PINS_PER_COLL;
  localparam int COLL_W   = (NUM_COLL > 1) ? $clog2(NUM_COLL) : 1;
  localparam int SEL_W    = 2 * PINS_PER_COLL;

  // address decode
  logic              win_hit;
  logic [COLL_W-1:0] coll_idx;
  logic [2:0]        win_byte;

  always_comb begin
    win_hit  = in_window(int'(reg_addr), BASE_ADDR, NUM_COLL);
    coll_idx = win_hit ? COLL_W'(coll_of(int'(reg_addr), BASE_ADDR)) : '0;
    win_byte = byte_of(int'(reg_addr), BASE_ADDR);
  end

  // named events for the checker
  logic wr_accepted, wr_ignored, unmapped_rd;
  assign wr_accepted = reg_wr && win_hit && byte_is_rw(win_byte);
  assign wr_ignored  = reg_wr && !wr_accepted;

  // per-collection state
  logic [SEL_W-1:0]         sel_arr [NUM_COLL];
  logic [PINS_PER_COLL-1:0] drv_arr [NUM_COLL];
  logic [PINS_PER_COLL-1:0] lvl_arr [NUM_COLL];
  logic [PINS_PER_COLL-1:0] in_arr  [NUM_COLL];

  logic [2*NUM_PINS-1:0] sel_vec;
  logic [NUM_PINS-1:0]   drv_vec, lvl_vec, in_sync;
  logic [NUM_PINS-1:0]   gpio_mask, a_mask, b_mask, c_mask;

  for (genvar c = 0; c < NUM_COLL; c++) begin : g_coll
    logic we;
    assign we = wr_accepted && (coll_idx == COLL_W'(c));

    pmx_coll_regs #(.NPIN(PINS_PER_COLL)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (we),
      .wr_byte (win_byte),
      .wdata   (reg_wdata),
      .sel_q   (sel_arr[c]),
      .drv_q   (drv_arr[c]),
      .lvl_q   (lvl_arr[c])
    );

    assign sel_vec[c*SEL_W +: SEL_W]                  = sel_arr[c];
    assign drv_vec[c*PINS_PER_COLL +: PINS_PER_COLL]  = drv_arr[c];
    assign lvl_vec[c*PINS_PER_COLL +: PINS_PER_COLL]  = lvl_arr[c];
    assign in_arr[c] = in_sync[c*PINS_PER_COLL +: PINS_PER_COLL];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
    assign gpio_mask[p] = (sel_vec[2*p +: 2] == SEL_GPIO);
    assign a_mask[p]    = (sel_vec[2*p +: 2] == SEL_CLI_A);
    assign b_mask[p]    = (sel_vec[2*p +: 2] == SEL_CLI_B);
    assign c_mask[p]    = (sel_vec[2*p +: 2] == SEL_CLI_C);
  end

  pmx_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .sel_vec  (sel_vec),
    .gpio_drv (drv_vec),
    .gpio_lvl (lvl_vec),
    .a_out    (cli_a_out),
    .a_oe     (cli_a_oe),
    .b_out    (cli_b_out),
    .b_oe     (cli_b_oe),
    .c_out    (cli_c_out),
    .c_oe     (cli_c_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  pmx_in_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  // read mux
  always_comb begin
    reg_rdata   = '0;
    unmapped_rd = 1'b1;
    if (win_hit) begin
      unmapped_rd = 1'b0;
      case (win_byte)
        WB_SEL_LO: reg_rdata = sel_arr[coll_idx][7:0];
        WB_SEL_HI: reg_rdata = sel_arr[coll_idx][15:8];
        WB_DRIVE:  reg_rdata = drv_arr[coll_idx];
        WB_LEVEL:  reg_rdata = lvl_arr[coll_idx];
        WB_PADIN:  reg_rdata = in_arr[coll_idx];
        default:   unmapped_rd = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/pmx_checker.sv
module pmx_checker #(
  parameter int NUM_PINS = 144
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [7:0]            reg_rdata,
  input logic [NUM_PINS-1:0]   pad_in,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   cli_a_out,
  input logic [NUM_PINS-1:0]   cli_a_oe,
  input logic [NUM_PINS-1:0]   cli_b_out,
  input logic [NUM_PINS-1:0]   cli_c_out,
  input logic [NUM_PINS-1:0]   drv_vec,
  input logic [NUM_PINS-1:0]   lvl_vec,
  input logic [2*NUM_PINS-1:0] sel_vec,
  input logic [NUM_PINS-1:0]   in_sync,
  input logic [NUM_PINS-1:0]   gpio_mask,
  input logic [NUM_PINS-1:0]   a_mask,
  input logic [NUM_PINS-1:0]   b_mask,
  input logic [NUM_PINS-1:0]   c_mask,
  input logic                  unmapped_rd,
  input logic                  wr_ignored
);

  logic       wr_seen;
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen <= 1'b0;
      cyc     <= '0;
    end else begin
      if (reg_wr) wr_seen <= 1'b1;
      if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end
  end

  a_r1_idle_until_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen |-> (pad_oe == '0));

  a_r3_gpio_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ drv_vec) & gpio_mask) == '0);

  a_r3_gpio_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ lvl_vec) & gpio_mask) == '0);

  a_r4_client_a: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ cli_a_out) & a_mask) == '0);

  a_r4_client_b: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ cli_b_out) & b_mask) == '0);

  a_r4_client_c: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ cli_c_out) & c_mask) == '0);

  a_r5_client_oe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ cli_a_oe) & a_mask) == '0);

  a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2) |-> (in_sync == $past(pad_in, 2)));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |-> (reg_rdata == 8'h00));

  a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(sel_vec) && $stable(drv_vec) && $stable(lvl_vec)));

endmodule

bind pinmux_gpio_bank pmx_checker #(.NUM_PINS(NUM_PINS)) u_pmx_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rdata   (reg_rdata),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .cli_a_out   (cli_a_out),
  .cli_a_oe    (cli_a_oe),
  .cli_b_out   (cli_b_out),
  .cli_c_out   (cli_c_out),
  .drv_vec     (drv_vec),
  .lvl_vec     (lvl_vec),
  .sel_vec     (sel_vec),
  .in_sync     (in_sync),
  .gpio_mask   (gpio_mask),
  .a_mask      (a_mask),
  .b_mask      (b_mask),
  .c_mask      (c_mask),
  .unmapped_rd (unmapped_rd),
  .wr_ignored  (wr_ignored)
);

// File: tb/pinmux_gpio_bank_tb.sv
module pinmux_gpio_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 144;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP-1:0] cli_a_out = {36{4'hA}};
  logic [NP-1:0] cli_a_oe  = {36{4'h5}};
  logic [NP-1:0] cli_b_out = {36{4'h3}};
  logic [NP-1:0] cli_b_oe  = {36{4'hC}};
  logic [NP-1:0] cli_c_out = {36{4'h6}};
  logic [NP-1:0] cli_c_oe  = {36{4'h9}};

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .cli_a_out(cli_a_out), .cli_a_oe(cli_a_oe),
    .cli_b_out(cli_b_out), .cli_b_oe(cli_b_oe),
    .cli_c_out(cli_c_out), .cli_c_oe(cli_c_oe)
  );

  // scoreboard item: kind 0 = read data, 1 = pad_out bit, 2 = pad_oe bit, 3 = OR of pad_oe
  typedef struct {
    int         kind;
    int         idx;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sbq[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sbq.size() > 0) begin
        sb_item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = reg_rdata;
          1: act = {7'd0, pad_out[it.idx]};
          2: act = {7'd0, pad_oe[it.idx]};
          default: act = {7'd0, |pad_oe};
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input int kind, input int idx, input logic [7:0] exp, input string tag);
    sb_item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    #2;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    chk(0, 0, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 reset state
    chk_rd(8'h20, 8'h00, "R1 sel byte after reset");
    chk_rd(8'hA3, 8'h00, "R1 level byte after reset");
    chk(3, 0, 8'h00, "R1 no pad enabled after reset");

    // R7 readback, R2/R4 selector placement and client routing (pins 8..11)
    wr(8'h28, 8'hE4);
    chk_rd(8'h28, 8'hE4, "R7 sel byte readback");
    chk(1, 9,  {7'd0, cli_a_out[9]},  "R4 pin9 client A out");
    chk(2, 9,  {7'd0, cli_a_oe[9]},   "R4 pin9 client A oe");
    chk(1, 10, {7'd0, cli_b_out[10]}, "R4 pin10 client B out");
    chk(2, 10, {7'd0, cli_b_oe[10]},  "R4 pin10 client B oe");
    chk(1, 11, {7'd0, cli_c_out[11]}, "R4 pin11 client C out");
    chk(2, 11, {7'd0, cli_c_oe[11]},  "R4 pin11 client C oe");

    // R2 high selector byte of the last collection: pin 143 -> client A
    wr(8'hA9, 8'h40);
    chk_rd(8'hA9, 8'h40, "R7 high sel byte readback");
    chk(1, 143, {7'd0, cli_a_out[143]}, "R2 pin143 from byte1 bits7:6");
    chk(2, 142, 8'h00, "R2 pin142 still GPIO input");

    // R3 GPIO drive and level on collection 0
    wr(8'h22, 8'h05);
    wr(8'h23, 8'h01);
    chk(2, 0, 8'h01, "R3 pin0 driven");
    chk(1, 0, 8'h01, "R3 pin0 level high");
    chk(2, 2, 8'h01, "R3 pin2 driven");
    chk(1, 2, 8'h00, "R3 pin2 level low");
    chk(2, 1, 8'h00, "R3 pin1 input");

    // R5 client owns pin9 despite GPIO drive/level
    wr(8'h2A, 8'hFF);
    wr(8'h2B, 8'h00);
    chk(2, 9, {7'd0, cli_a_oe[9]},  "R5 pin9 oe ignores drive");
    chk(1, 9, {7'd0, cli_a_out[9]}, "R5 pin9 out ignores level");
    chk(2, 8, 8'h01, "R3 pin8 GPIO driven");
    wr(8'h28, 8'h00);
    chk(2, 9, 8'h01, "R5 pin9 drive back in effect");
    chk(1, 9, 8'h00, "R5 pin9 level back in effect");

    // R8 unmapped bytes and addresses
    wr(8'h24, 8'hFF);
    chk_rd(8'h24, 8'h00, "R8 byte4 reads zero");
    wr(8'h2D, 8'hFF);
    chk_rd(8'h2D, 8'h00, "R8 byte5 reads zero");
    wr(8'h2F, 8'hFF);
    chk_rd(8'h2F, 8'h00, "R8 byte7 reads zero");
    wr(8'h10, 8'hFF);
    chk_rd(8'h10, 8'h00, "R8 below base reads zero");
    wr(8'hB0, 8'hFF);
    chk_rd(8'hB0, 8'h00, "R8 past last window reads zero");
    chk_rd(8'h1F, 8'h00, "R8 just below base reads zero");
    wr(8'h26, 8'hFF);
    chk_rd(8'h26, 8'h00, "R8 write to input byte ignored");
    chk_rd(8'h2A, 8'hFF, "R8 drive intact after ignored writes");
    chk(2, 9, 8'h01, "R8 pin9 pad unchanged");

    // R9 other bytes and collections untouched
    chk_rd(8'h20, 8'h00, "R9 coll0 sel untouched");
    chk_rd(8'h22, 8'h05, "R9 coll0 drive untouched");
    chk_rd(8'h23, 8'h01, "R9 coll0 level untouched");

    // R6 two-stage input path
    @(negedge clk);
    pad_in[43] = 1'b1;
    chk_rd(8'h4E, 8'h00, "R6 after one edge still old");
    chk_rd(8'h4E, 8'h08, "R6 after two edges new");
    @(negedge clk);
    pad_in[143:136] = 8'hA5;
    chk_rd(8'hAE, 8'h00, "R6 coll17 after one edge");
    chk_rd(8'hAE, 8'hA5, "R6 coll17 after two edges");

    @(posedge clk); #3;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule